// File: doc/BRIEF.md
# Incremental Fixed-Point PID Controller

This block is a digital PID loop filter in velocity form. It sits between a converter that delivers a signed error word on each sample strobe and a converter that turns the control word back into an analog drive. Each new control value is built from the previous control value plus three weighted error terms. The weights act on the newest error and on the two errors before it.

The three gains are loaded at run time through a small write port. The controller structure itself is fixed. The four-operand sum goes through two levels of carry-save reduction and then a single carry-propagate adder. The result is rounded to the nearest integer and clamped to a programmable window. The clamped value, not the raw sum, is what the loop remembers as the previous output, so the controller cannot wind up while it is saturated.

Top module: `pid_incr_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the control output, both stored past errors and all three gains to zero, and drives `outValid` low.
- R2: On a sample, the new output is clamp(round((u_prev·4096 + G0·e[k] + G1·e[k-1] + G2·e[k-2]) / 4096)). Errors and output are signed 16-bit integers. Gains are signed 16-bit with 12 fraction bits (4096 represents 1.0).
- R3: The two past-error registers shift only on a cycle with `sampleValid` high. The newest error moves into the first register and the first register's old value moves into the second. Idle cycles leave both unchanged.
- R4: Rounding adds 2048 to the full-precision sum and then shifts it arithmetically right by 12, so halves round toward positive infinity (+0.5 gives 1, -1.5 gives -1).
- R5: The rounded value is clamped into [`limLo`, `limHi`] (signed, with `limLo` ≤ `limHi`). It never wraps, even when the unclamped sum exceeds the 16-bit range.
- R6: The stored previous output is the clamped value. After saturation, a reversing error moves the output away from the limit on the very next sample.
- R7: `ctrlOut` changes only one clock after a cycle with `sampleValid` high. `outValid` is high for exactly that one cycle and low otherwise, and `ctrlOut` holds its value between samples.
- R8: A write with `gainWrEn` high loads `gainData` into gain G0, G1 or G2 when `gainSel` is 0, 1 or 2. `gainSel` = 3 changes nothing. A write in the same cycle as a sample does not affect that sample; it applies from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | Sample strobe; advances the error history and updates the output |
| errIn | input | 16 | Signed error word for the current sample |
| gainWrEn | input | 1 | Gain write enable |
| gainSel | input | 2 | Gain select: 0 = G0 (newest error), 1 = G1, 2 = G2 (oldest), 3 = none |
| gainData | input | 16 | Signed Q4.12 gain value to write |
| limHi | input | 16 | Signed upper output limit |
| limLo | input | 16 | Signed lower output limit |
| ctrlOut | output | 16 | Signed control word for the output converter |
| outValid | output | 1 | One-cycle pulse marking a fresh `ctrlOut` |

## Verification
The bench drives the largest gains and errors so that the unclamped sum exceeds the 16-bit range many times over. A design that wraps instead of clamping would show a sign flip at that point. It checks negative and positive half-way values, where rounding by truncation or toward zero would be off by one. It also reverses the error right after saturation, where a design that keeps the raw sum would stay pinned at the limit. Gain writes in the same cycle as a sample, writes to the unused select code, and idle gaps between samples expose a design that applies gains early, corrupts a gain on the spare code, or shifts its error history without a strobe.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int NUM_TAPS = 3;

  typedef struct packed {
    logic                clearAll;
    logic                shiftTaps;
    logic                loadOut;
    logic [NUM_TAPS-1:0] gainWr;
  } pid_strobe_t;
endpackage

// File: rtl/pid_csa3.sv
module pid_csa3 #(
  parameter int W = 35
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumVec,
  output logic [W-1:0] carryVec
);
  logic [W-1:0] majVec;

  // one full adder per bit, carries kept apart
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign sumVec[b] = inA[b] ^ inB[b] ^ inC[b];
    assign majVec[b] = (inA[b] & inB[b]) | (inA[b] & inC[b]) | (inB[b] & inC[b]);
  end

  assign carryVec = {majVec[W-2:0], 1'b0};
endmodule

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  input  logic        gainWrEn,
  input  logic [1:0]  gainSel,
  output pid_strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clearAll  = rst;
    strobe.shiftTaps = sampleValid & ~rst;
    strobe.loadOut   = sampleValid & ~rst;
    for (int t = 0; t < NUM_TAPS; t++) begin
      strobe.gainWr[t] = gainWrEn & ~rst & (gainSel == 2'(t));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= sampleValid;
  end

  // R7: valid pulse follows the strobe by exactly one clock
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> outValid);
  a_r7_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> !outValid);
  // R8: the spare select code raises no write strobe
  a_r8_spare_sel: assert property (@(posedge clk) disable iff (rst)
    (gainSel == 2'd3) |-> (strobe.gainWr == '0));
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  pid_strobe_t              strobe,
  input  logic signed [DATA_W-1:0] errIn,
  input  logic signed [DATA_W-1:0] gainData,
  input  logic signed [DATA_W-1:0] limHi,
  input  logic signed [DATA_W-1:0] limLo,
  output logic signed [DATA_W-1:0] ctrlOut
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + 3;
  localparam int RND_W  = ACC_W - FRAC_W;
  localparam int UEXT_W = ACC_W - DATA_W - FRAC_W;

  logic signed [DATA_W-1:0] gainReg [NUM_TAPS];
  logic signed [DATA_W-1:0] tapVal  [NUM_TAPS];
  logic signed [PROD_W-1:0] prodVal [NUM_TAPS];
  logic        [ACC_W-1:0]  prodOp  [NUM_TAPS];
  logic signed [DATA_W-1:0] errD1, errD2, uReg;
  logic        [ACC_W-1:0]  uOp;

  // gain registers, one per tap
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_gain
    always_ff @(posedge clk) begin
      if (strobe.clearAll)      gainReg[t] <= '0;
      else if (strobe.gainWr[t]) gainReg[t] <= gainData;
    end
  end

  // error history
  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      errD1 <= '0;
      errD2 <= '0;
    end else if (strobe.shiftTaps) begin
      errD1 <= errIn;
      errD2 <= errD1;
    end
  end

  assign tapVal[0] = errIn;
  assign tapVal[1] = errD1;
  assign tapVal[2] = errD2;

  // full-precision products, sign-extended to accumulator width
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_mul
    assign prodVal[t] = tapVal[t] * gainReg[t];
    assign prodOp[t]  = {{(ACC_W-PROD_W){prodVal[t][PROD_W-1]}}, prodVal[t]};
  end

  // previous output aligned to the fraction point; the empty fraction
  // field carries the rounding half-LSB for free
  assign uOp = {{UEXT_W{uReg[DATA_W-1]}}, uReg, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [ACC_W-1:0] s1, c1, s2, c2, accSum;

  pid_csa3 #(.W(ACC_W)) u_csa_lvl1 (
    .inA(uOp), .inB(prodOp[0]), .inC(prodOp[1]),
    .sumVec(s1), .carryVec(c1)
  );
  pid_csa3 #(.W(ACC_W)) u_csa_lvl2 (
    .inA(s1), .inB(c1), .inC(prodOp[2]),
    .sumVec(s2), .carryVec(c2)
  );

  assign accSum = s2 + c2;

  // rounding (bias already inside uOp) and clamping
  logic signed [RND_W-1:0]  rndVal, hiExt, loExt;
  logic signed [DATA_W-1:0] nextU;

  assign rndVal = accSum[ACC_W-1:FRAC_W];
  assign hiExt  = {{(RND_W-DATA_W){limHi[DATA_W-1]}}, limHi};
  assign loExt  = {{(RND_W-DATA_W){limLo[DATA_W-1]}}, limLo};

  always_comb begin
    if (rndVal > hiExt)      nextU = limHi;
    else if (rndVal < loExt) nextU = limLo;
    else                     nextU = rndVal[DATA_W-1:0];
  end

  // clamped value is both the output and the stored u[k-1]
  always_ff @(posedge clk) begin
    if (strobe.clearAll)    uReg <= '0;
    else if (strobe.loadOut) uReg <= nextU;
  end

  assign ctrlOut = uReg;

  // R2: carry-save path agrees with a plain four-operand sum
  a_r2_csa_sum: assert property (@(posedge clk) disable iff (strobe.clearAll)
    accSum == (uOp + prodOp[0] + prodOp[1] + prodOp[2]));
  // R3: history holds without a strobe, shifts in order with one
  a_r3_taps_hold: assert property (@(posedge clk) disable iff (strobe.clearAll)
    !strobe.shiftTaps |=> ($stable(errD1) && $stable(errD2)));
  a_r3_taps_shift: assert property (@(posedge clk) disable iff (strobe.clearAll)
    strobe.shiftTaps |=> (errD2 == $past(errD1) && errD1 == $past(errIn)));
  // R5: loaded output lies inside the window in force at the load
  a_r5_in_window: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (strobe.loadOut && limLo <= limHi) |=> (uReg <= $past(limHi) && uReg >= $past(limLo)));
  // R7: output holds between samples
  a_r7_out_hold: assert property (@(posedge clk) disable iff (strobe.clearAll)
    !strobe.loadOut |=> $stable(uReg));
endmodule

// File: rtl/pid_incr_ctrl.sv
module pid_incr_ctrl
  import pid_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] errIn,
  input  logic                     gainWrEn,
  input  logic [1:0]               gainSel,
  input  logic signed [DATA_W-1:0] gainData,
  input  logic signed [DATA_W-1:0] limHi,
  input  logic signed [DATA_W-1:0] limLo,
  output logic signed [DATA_W-1:0] ctrlOut,
  output logic                     outValid
);
  pid_strobe_t strobe;

  pid_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .gainWrEn(gainWrEn), .gainSel(gainSel),
    .strobe(strobe), .outValid(outValid)
  );

  pid_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .strobe(strobe), .errIn(errIn), .gainData(gainData),
    .limHi(limHi), .limLo(limLo), .ctrlOut(ctrlOut)
  );
endmodule

// File: tb/pid_incr_ctrl_tb.sv
`timescale 1ns/1ps
module pid_incr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleValid = 1'b0;
  logic [15:0] errIn = '0;
  logic        gainWrEn = 1'b0;
  logic [1:0]  gainSel = '0;
  logic [15:0] gainData = '0;
  logic [15:0] limHi = 16'h7FFF;
  logic [15:0] limLo = 16'h8000;
  logic [15:0] ctrlOut;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int mK [3];
  int mE1, mE2, mU, mHi, mLo;

  always #4 clk = ~clk;

  pid_incr_ctrl dut_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .errIn(errIn),
    .gainWrEn(gainWrEn), .gainSel(gainSel), .gainData(gainData),
    .limHi(limHi), .limLo(limLo), .ctrlOut(ctrlOut), .outValid(outValid)
  );

  function automatic int s16(logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int modelStep(int e);
    longint acc;
    longint r;
    acc = longint'(mU) * 4096 + longint'(mK[0]) * e + longint'(mK[1]) * mE1
        + longint'(mK[2]) * mE2 + 2048;
    r = acc >>> 12;
    if (r > mHi) r = mHi;
    if (r < mLo) r = mLo;
    return int'(r);
  endfunction

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setLimits(int lo, int hi);
    @(negedge clk);
    limLo = 16'(lo); limHi = 16'(hi);
    mLo = lo; mHi = hi;
  endtask

  task automatic writeGain(int sel, int val);
    @(negedge clk);
    gainWrEn = 1'b1; gainSel = 2'(sel); gainData = 16'(val);
    @(negedge clk);
    gainWrEn = 1'b0;
    if (sel < 3) mK[sel] = s16(16'(val));
  endtask

  // sample with optional gain write in the same cycle
  task automatic doSample(string req, int e, bit wr = 0, int sel = 0, int val = 0);
    int exp;
    @(negedge clk);
    sampleValid = 1'b1; errIn = 16'(e);
    if (wr) begin gainWrEn = 1'b1; gainSel = 2'(sel); gainData = 16'(val); end
    exp = modelStep(e);
    @(negedge clk);
    sampleValid = 1'b0; gainWrEn = 1'b0;
    checkEq({req, " outValid"}, int'(outValid), 1);
    checkEq(req, s16(ctrlOut), exp);
    mE2 = mE1; mE1 = e; mU = exp;
    if (wr && sel < 3) mK[sel] = s16(16'(val));
  endtask

  task automatic idle(int n);
    int held;
    held = s16(ctrlOut);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkEq("R7 idle outValid", int'(outValid), 0);
      checkEq("R7 idle hold", s16(ctrlOut), held);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mK[0] = 0; mK[1] = 0; mK[2] = 0; mE1 = 0; mE2 = 0; mU = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mHi = 32767; mLo = -32768;
    mK[0] = 0; mK[1] = 0; mK[2] = 0; mE1 = 0; mE2 = 0; mU = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checkEq("R1 reset ctrlOut", s16(ctrlOut), 0);
    checkEq("R1 reset outValid", int'(outValid), 0);
    doSample("R1 zero gains after reset", 1234);
    doReset();
    // R8 write each gain; R2 basic equation
    writeGain(0, 16'h1000);
    doSample("R8 gain0 write", 100);
    writeGain(1, 16'hF000);
    writeGain(2, 16'h0800);
    doSample("R2 three taps", -250);
    idle(3);
    doSample("R3 history after idle", 40);
    doSample("R2 history", 7);
    // R8 spare select ignored
    writeGain(3, 16'h7FFF);
    doSample("R8 spare select", 300);
    // R8 concurrent write uses old gain, next sample new
    doSample("R8 same-cycle write", 55, 1'b1, 0, 16'h2000);
    doSample("R8 write applied next", 55);
    // R4 rounding halves
    doReset();
    writeGain(0, 16'h0800);
    doSample("R4 +0.5 rounds up", 1);
    doReset();
    writeGain(0, 16'h0800);
    doSample("R4 -1.5 rounds to -1", -3);
    checkEq("R4 directed -1", mU, -1);
    // R5 clamp to narrow window, both sides
    doReset();
    setLimits(-1000, 1000);
    writeGain(0, 16'h7FFF);
    doSample("R5 clamp high", 32767);
    checkEq("R5 high value", mU, 1000);
    writeGain(0, 16'h1000);
    doSample("R6 no windup", -10);
    checkEq("R6 directed 990", mU, 990);
    writeGain(0, 16'h7FFF);
    doSample("R5 clamp low", -32768);
    checkEq("R5 low value", mU, -1000);
    // R5 full range overflow, no sign flip
    doReset();
    setLimits(-32768, 32767);
    writeGain(0, 16'h7FFF); writeGain(1, 16'h7FFF); writeGain(2, 16'h7FFF);
    doSample("R5 overflow 1", 32767);
    doSample("R5 overflow 2", 32767);
    doSample("R5 overflow 3", 32767);
    checkEq("R5 no wrap", mU, 32767);
    writeGain(0, 16'h8000); writeGain(1, 16'h8000); writeGain(2, 16'h8000);
    doSample("R5 underflow", 32767);
    checkEq("R5 no wrap neg", mU, -32768);
    // random mix
    doReset();
    for (int n = 0; n < 600; n++) begin
      int e;
      if (n % 40 == 0) begin
        int a, b;
        if ($urandom_range(0, 3) == 0) begin a = -32768; b = 32767; end
        else begin
          a = int'($urandom_range(0, 65535)) - 32768;
          b = int'($urandom_range(0, 65535)) - 32768;
        end
        if (a > b) setLimits(b, a); else setLimits(a, b);
      end
      if (n % 25 == 0) begin
        for (int g = 0; g < 3; g++) writeGain(g, int'($urandom_range(0, 8191)) - 4096);
      end
      if ($urandom_range(0, 4) == 0) e = int'($urandom_range(0, 65535)) - 32768;
      else e = int'($urandom_range(0, 2047)) - 1024;
      if ($urandom_range(0, 9) == 0)
        doSample("R2 random with write", e, 1'b1, int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 8191)) - 4096);
      else
        doSample("R2 random", e);
      if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 2)));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule